// File: doc/BRIEF.md
# Serial Frame Auto-Transfer Controller

This block sits on the far side of an isolated three-wire link and drives the control pins of a 16-bit converter's input interface. Only a serial data line, a data strobe and a reset line reach it. Every rising edge of the strobe becomes one active-low write pulse, and the sampled data bit is presented on the converter's data pin. Both byte-enable lines stay low, so the converter's input register pair stays in serial shift mode.

A frame counter tracks the written bits. When the sixteenth bit of a frame has been written, the block issues one active-low transfer pulse on the converter-register enable. That pulse copies the assembled word into the output register, so no load line has to cross the isolation barrier. The counter then wraps, and the next strobe starts a new frame.

The link reset is forwarded as the converter's clear line. It also throws away any partial frame, so framing recovers after a glitch. All three link inputs pass through synchronizer chains before they are used.

Top module: `serial_frame_loader`

## Requirements
- R1: After `rst`, `dac_wr_n`, `dac_xfer_n` and `dac_clr_n` are 1 and `dac_data` is 0.
- R2: `dac_lsel_n` and `dac_hsel_n` are always 0, which keeps the converter in serial shift mode.
- R3: Each rising edge of `iso_strobe` produces exactly one low pulse on `dac_wr_n`, lasting WR_CYCLES clocks. If the strobe is first sampled high at clock edge k, the pulse begins at edge k+SYNC_STAGES.
- R4: During a write pulse, `dac_data` carries the `iso_data` value that was sampled together with the strobe edge, and it is stable for the whole pulse.
- R5: A frame is FRAME_BITS (16) bits long and is sent most significant bit first. Shifting the written bits into the converter's register, one per rising edge of `dac_wr_n`, yields the frame word.
- R6: After every 16th write of a frame, `dac_xfer_n` falls at the edge where `dac_wr_n` returns high and stays low for XFER_CYCLES clocks. No other write is followed by a transfer.
- R7: `dac_wr_n` and `dac_xfer_n` are never low at the same time.
- R8: A strobe edge that arrives while a write or transfer pulse is running is held. Its write is issued once the pulse ends, and it counts as the next bit of the frame, including as bit 1 of the following frame.
- R9: `iso_reset` drives `dac_clr_n` low with the same SYNC_STAGES latency, for as long as it stays high. The clear aborts any running pulse, discards a partial frame, resets the bit count to zero and ignores strobe edges while it is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_data | input | 1 | Serial data from the link |
| iso_strobe | input | 1 | Data strobe from the link; rising edge means one bit |
| iso_reset | input | 1 | Reset from the link, active high |
| dac_data | output | 1 | Serial data bit to the converter |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| dac_lsel_n | output | 1 | Low-byte / serial enable, held low |
| dac_hsel_n | output | 1 | High-byte / serial enable, held low |
| dac_xfer_n | output | 1 | Converter-register enable (transfer pulse), active low |
| dac_clr_n | output | 1 | Converter clear, active low |

## Verification
If a strobe or reset is first sampled high at edge k, the write pulse or clear appears at edge k+2 under the default two-stage synchronizer. The write pulse ends at edge k+2+WR_CYCLES, and on the sixteenth bit the transfer pulse covers edges k+2+WR_CYCLES up to k+2+WR_CYCLES+XFER_CYCLES. The bench drives its inputs on falling edges and samples on falling edges. It counts falling edges after each stimulus, so it expects the write low at the third sample, the write high and transfer low at the seventh sample, and the transfer high at the tenth. Frame contents are checked only after the transfer window has closed, by a model that shifts one bit on each rising edge of the write strobe.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WRITE = 2'd1,
        SEQ_XFER  = 2'd2
    } seq_state_e;

    // One detected strobe edge together with its data bit
    typedef struct packed {
        logic valid;
        logic bit_val;
    } strobe_ev_t;

    // Everything the block presents to the converter, except the fixed enables
    typedef struct packed {
        logic data;
        logic wr_n;
        logic xfer_n;
        logic clr_n;
    } dac_ctl_t;

    localparam dac_ctl_t CTL_IDLE = '{data: 1'b0, wr_n: 1'b1, xfer_n: 1'b1, clr_n: 1'b1};

    // Width of a down-counter that is loaded with (cycles - 1)
    function automatic int unsigned timer_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

    // Width of a counter that runs 0 .. n-1
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sfl_edge.sv
module sfl_edge
    import sfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_s,
    input  logic       data_s,
    input  logic       clr_s,
    output strobe_ev_t ev
);

    logic strobe_q;

    // The previous level is tracked during a clear as well, so a strobe
    // held high across the end of a clear is not taken as a new edge.
    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe_s;
    end

    assign ev.valid   = strobe_s & ~strobe_q & ~clr_s;
    assign ev.bit_val = data_s;

endmodule

// File: rtl/sfl_timer.sv
module sfl_timer #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clear)      remain <= '0;
        else if (load)         remain <= load_val;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign zero = (remain == '0);

endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
    import sfl_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned WR_CYCLES   = 4,
    parameter int unsigned XFER_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  strobe_ev_t ev,
    input  logic       clr_s,
    output dac_ctl_t   ctl
);

    localparam int unsigned CW = count_width(FRAME_BITS);
    localparam int unsigned TW = timer_width(WR_CYCLES, XFER_CYCLES);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);
    localparam logic [TW-1:0] WR_LOAD  = TW'(WR_CYCLES - 1);
    localparam logic [TW-1:0] XF_LOAD  = TW'(XFER_CYCLES - 1);

    seq_state_e    state;
    logic [CW-1:0] bit_cnt;
    strobe_ev_t    pend;
    strobe_ev_t    cand;
    logic          last_bit;
    logic          take;
    logic          frame_end;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          start_xfer;

    // A held strobe always goes before a fresh one
    assign cand       = pend.valid ? pend : ev;
    assign take       = (state == SEQ_IDLE) && cand.valid;
    assign frame_end  = (bit_cnt == LAST_IDX);
    assign start_xfer = (state == SEQ_WRITE) && tmr_zero && last_bit;
    assign tmr_load   = take || start_xfer;
    assign tmr_val    = take ? WR_LOAD : XF_LOAD;

    sfl_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (clr_s),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            bit_cnt  <= '0;
            pend     <= '0;
            last_bit <= 1'b0;
            ctl      <= CTL_IDLE;
        end else begin
            ctl.clr_n <= ~clr_s;
            if (clr_s) begin
                state      <= SEQ_IDLE;
                bit_cnt    <= '0;
                pend       <= '0;
                last_bit   <= 1'b0;
                ctl.wr_n   <= 1'b1;
                ctl.xfer_n <= 1'b1;
            end else begin
                unique case (state)
                    SEQ_IDLE: begin
                        if (take) begin
                            ctl.data <= cand.bit_val;
                            ctl.wr_n <= 1'b0;
                            last_bit <= frame_end;
                            bit_cnt  <= frame_end ? '0 : bit_cnt + 1'b1;
                            pend     <= pend.valid ? ev : '0;
                            state    <= SEQ_WRITE;
                        end
                    end
                    SEQ_WRITE: begin
                        if (ev.valid) pend <= ev;
                        if (tmr_zero) begin
                            ctl.wr_n <= 1'b1;
                            if (last_bit) begin
                                ctl.xfer_n <= 1'b0;
                                state      <= SEQ_XFER;
                            end else begin
                                state <= SEQ_IDLE;
                            end
                        end
                    end
                    SEQ_XFER: begin
                        if (ev.valid) pend <= ev;
                        if (tmr_zero) begin
                            ctl.xfer_n <= 1'b1;
                            state      <= SEQ_IDLE;
                        end
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_frame_loader.sv
module serial_frame_loader
    import sfl_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WR_CYCLES   = 4,
    parameter int unsigned XFER_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic iso_data,
    input  logic iso_strobe,
    input  logic iso_reset,
    output logic dac_data,
    output logic dac_wr_n,
    output logic dac_lsel_n,
    output logic dac_hsel_n,
    output logic dac_xfer_n,
    output logic dac_clr_n
);

    localparam int unsigned LINK_W = 3;

    logic [LINK_W-1:0] link_s;
    strobe_ev_t        ev;
    dac_ctl_t          ctl;

    // All three link lines share one chain so they stay cycle-aligned
    sfl_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINK_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({iso_reset, iso_strobe, iso_data}),
        .q   (link_s)
    );

    sfl_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_s (link_s[1]),
        .data_s   (link_s[0]),
        .clr_s    (link_s[2]),
        .ev       (ev)
    );

    sfl_seq #(
        .FRAME_BITS  (FRAME_BITS),
        .WR_CYCLES   (WR_CYCLES),
        .XFER_CYCLES (XFER_CYCLES)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .clr_s (link_s[2]),
        .ctl   (ctl)
    );

    assign dac_data   = ctl.data;
    assign dac_wr_n   = ctl.wr_n;
    assign dac_xfer_n = ctl.xfer_n;
    assign dac_clr_n  = ctl.clr_n;
    // Both byte enables low selects serial shift mode permanently
    assign dac_lsel_n = 1'b0;
    assign dac_hsel_n = 1'b0;

endmodule

// File: rtl/sfl_checker.sv
module sfl_checker #(
    parameter int unsigned WR_CYCLES   = 4,
    parameter int unsigned XFER_CYCLES = 3
) (
    input logic clk,
    input logic rst,
    input logic dac_wr_n,
    input logic dac_xfer_n,
    input logic dac_clr_n,
    input logic dac_data
);

    localparam int unsigned MAXC = (WR_CYCLES > XFER_CYCLES) ? WR_CYCLES : XFER_CYCLES;
    localparam int unsigned LW   = $clog2(MAXC + 2) + 1;

    logic [LW-1:0] wr_len;
    logic [LW-1:0] xf_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_len <= '0;
            xf_len <= '0;
        end else begin
            wr_len <= !dac_wr_n   ? ((wr_len != '1) ? wr_len + 1'b1 : wr_len) : '0;
            xf_len <= !dac_xfer_n ? ((xf_len != '1) ? xf_len + 1'b1 : xf_len) : '0;
        end
    end

    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(dac_wr_n) && dac_clr_n) |-> (wr_len == LW'(WR_CYCLES))); // R3

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!dac_wr_n && $past(!dac_wr_n)) |-> $stable(dac_data)); // R4

    AST_XFER_ON_WR_END: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_xfer_n) |-> $rose(dac_wr_n)); // R6

    AST_XFER_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(dac_xfer_n) && dac_clr_n) |-> (xf_len == LW'(XFER_CYCLES))); // R6

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(!dac_wr_n && !dac_xfer_n)); // R7

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dac_clr_n |-> (dac_wr_n && dac_xfer_n)); // R9

endmodule

bind serial_frame_loader sfl_checker #(
    .WR_CYCLES   (WR_CYCLES),
    .XFER_CYCLES (XFER_CYCLES)
) u_sfl_checker (
    .clk        (clk),
    .rst        (rst),
    .dac_wr_n   (dac_wr_n),
    .dac_xfer_n (dac_xfer_n),
    .dac_clr_n  (dac_clr_n),
    .dac_data   (dac_data)
);

// File: tb/serial_frame_loader_bench.sv
`timescale 1ns/1ps
module serial_frame_loader_bench;

    localparam int FB  = 16;
    localparam int SS  = 2;
    localparam int WRC = 4;
    localparam int XFC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iso_data = 1'b0;
    logic iso_strobe = 1'b0;
    logic iso_reset = 1'b0;
    logic dac_data, dac_wr_n, dac_lsel_n, dac_hsel_n, dac_xfer_n, dac_clr_n;

    serial_frame_loader #(
        .FRAME_BITS (FB),
        .SYNC_STAGES(SS),
        .WR_CYCLES  (WRC),
        .XFER_CYCLES(XFC)
    ) u_serial_frame_loader (
        .clk        (clk),
        .rst        (rst),
        .iso_data   (iso_data),
        .iso_strobe (iso_strobe),
        .iso_reset  (iso_reset),
        .dac_data   (dac_data),
        .dac_wr_n   (dac_wr_n),
        .dac_lsel_n (dac_lsel_n),
        .dac_hsel_n (dac_hsel_n),
        .dac_xfer_n (dac_xfer_n),
        .dac_clr_n  (dac_clr_n)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Converter model: shift on write release, copy on transfer start, zero on clear
    logic [15:0] m_shift = '0;
    logic [15:0] m_latch = '0;
    logic [15:0] hist [64];
    int n_xfer = 0;
    int n_wr = 0;
    logic p_wr = 1'b1;
    logic p_xf = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            p_wr = 1'b1;
            p_xf = 1'b1;
        end else begin
            if (dac_wr_n && !p_wr && !dac_lsel_n && !dac_hsel_n) begin
                m_shift = {m_shift[14:0], dac_data};
                n_wr++;
            end
            if (!dac_xfer_n && p_xf) begin
                m_latch = m_shift;
                if (n_xfer < 64) hist[n_xfer] = m_shift;
                n_xfer++;
            end
            if (!dac_clr_n) begin
                m_shift = '0;
                m_latch = '0;
            end
            p_wr = dac_wr_n;
            p_xf = dac_xfer_n;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int hi, input int lo);
        iso_data   = b;
        iso_strobe = 1'b1;
        repeat (hi) @(negedge clk);
        iso_strobe = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] w, input int n, input int hi, input int lo);
        for (int i = 15; i >= 16 - n; i--) send_bit(w[i], hi, lo);
    endtask

    task automatic send_word(input logic [15:0] w, input int hi, input int lo);
        send_bits(w, 16, hi, lo);
    endtask

    initial begin
        int exp_x;
        int t_wl, t_wh, t_xl, t_xh;
        bit overlap;
        logic [15:0] w;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "wr_n after reset", dac_wr_n, 1);
        chk("R1", "xfer_n after reset", dac_xfer_n, 1);
        chk("R1", "clr_n after reset", dac_clr_n, 1);
        chk("R1", "data after reset", dac_data, 0);
        chk("R2", "lsel_n", dac_lsel_n, 0);
        chk("R2", "hsel_n", dac_hsel_n, 0);

        // Frame 0: fifteen bits, then a cycle-by-cycle look at the sixteenth
        send_bits(16'hA5C3, 15, 3, 7);
        chk("R6", "no transfer before 16th bit", n_xfer, 0);
        chk("R5", "writes after 15 bits", n_wr, 15);
        t_wl = -1; t_wh = -1; t_xl = -1; t_xh = -1; overlap = 1'b0;
        iso_data   = 1'b1;
        iso_strobe = 1'b1;
        for (int t = 1; t <= 30; t++) begin
            @(negedge clk);
            if (t == 3) iso_strobe = 1'b0;
            if (!dac_wr_n && !dac_xfer_n) overlap = 1'b1;
            if (!dac_wr_n && t_wl < 0) t_wl = t;
            if (dac_wr_n && t_wl >= 0 && t_wh < 0) t_wh = t;
            if (!dac_xfer_n && t_xl < 0) t_xl = t;
            if (dac_xfer_n && t_xl >= 0 && t_xh < 0) t_xh = t;
        end
        chk("R3", "write start sample", t_wl, SS + 1);
        chk("R3", "write end sample", t_wh, SS + 1 + WRC);
        chk("R6", "transfer start sample", t_xl, SS + 1 + WRC);
        chk("R6", "transfer end sample", t_xh, SS + 1 + WRC + XFC);
        chk("R7", "write and transfer overlap", overlap, 0);
        chk("R4 R5", "frame 0 word", hist[0], 16'hA5C3);
        chk("R6", "transfers after frame 0", n_xfer, 1);
        exp_x = 1;

        // Sweep: walking ones plus extreme patterns
        for (int k = 0; k < 20; k++) begin
            case (k)
                16:      w = 16'h0000;
                17:      w = 16'hFFFF;
                18:      w = 16'h8001;
                19:      w = 16'h7FFE;
                default: w = 16'(1) << k;
            endcase
            send_word(w, 3, 7);
            repeat (6) @(negedge clk);
            chk("R4 R5", "sweep word", hist[exp_x], w);
            exp_x++;
            chk("R6", "one transfer per frame", n_xfer, exp_x);
        end
        chk("R2", "lsel_n after sweep", dac_lsel_n, 0);
        chk("R2", "hsel_n after sweep", dac_hsel_n, 0);
        chk("R3", "writes so far", n_wr, 16 * 21);

        // Strobes landing inside a write pulse and inside a transfer pulse
        send_bits(16'h3C5A, 15, 3, 7);
        send_bit(1'b0, 2, 1);
        send_word(16'h9E01, 3, 7);
        repeat (8) @(negedge clk);
        send_bits(16'h0FF0, 15, 3, 7);
        send_bit(1'b0, 2, 4);
        send_word(16'hC3A5, 3, 7);
        repeat (8) @(negedge clk);
        chk("R8", "frame before held strobe", hist[exp_x], 16'h3C5A);
        chk("R8", "frame started during write", hist[exp_x + 1], 16'h9E01);
        chk("R8", "frame before transfer-time strobe", hist[exp_x + 2], 16'h0FF0);
        chk("R8", "frame started during transfer", hist[exp_x + 3], 16'hC3A5);
        exp_x += 4;
        chk("R8", "transfer count", n_xfer, exp_x);

        // Link reset during a running write, in the middle of a frame
        send_bits(16'hFFFF, 6, 3, 7);
        iso_data   = 1'b1;
        iso_strobe = 1'b1;
        @(negedge clk);
        iso_reset = 1'b1;
        @(negedge clk);
        chk("R9", "clear not yet active", dac_clr_n, 1);
        @(negedge clk);
        iso_strobe = 1'b0;
        chk("R3", "7th write running", dac_wr_n, 0);
        @(negedge clk);
        chk("R9", "clear active after sync", dac_clr_n, 0);
        chk("R9", "write aborted by clear", dac_wr_n, 1);
        send_bit(1'b1, 2, 2);
        send_bit(1'b0, 2, 2);
        chk("R9", "clear held", dac_clr_n, 0);
        chk("R9", "output register cleared", m_latch, 0);
        chk("R9", "no transfer from partial frame", n_xfer, exp_x);
        iso_reset = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", "clear released", dac_clr_n, 1);
        send_word(16'h1234, 3, 7);
        repeat (6) @(negedge clk);
        chk("R9", "frame after clear realigned", hist[exp_x], 16'h1234);
        chk("R9", "single transfer after clear", n_xfer, exp_x + 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule